// File: doc/BRIEF.md
# Gated Pulse Generator with Deferred and Queued Updates

This block produces an endless rectangular wave on `pulse_out`. Each period has a high phase and a low phase, and each phase is a count of system clock cycles, so the pair of counts sets both the frequency and the duty cycle. A gate input enables the output. The level at which the gate counts as active is chosen by `gate_pol`. While the gate is inactive the output rests low. When the gate comes back, a fresh period starts with a full high phase.

A new pair of counts never cuts into a period that is already running. The new pair is first held as a pending setting, and it is loaded only when the current low phase ends. The source of the pending setting depends on `mode_sel`. In static mode (`mode_sel`=0), software places `cfg_high`/`cfg_low` there by pulsing `cfg_load`. In queued mode (`mode_sel`=1), each rising edge of the sample clock `smp_clk` takes the oldest entry from a 16-deep FIFO and discards it from the FIFO.

The FIFO is filled through a valid/ready write port. A beat is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while the FIFO is full. A producer should therefore hold its beat until `wr_ready` is high. A beat offered while `wr_ready` is low is dropped and recorded in a sticky flag. It is not stalled.

Top module: `gated_pulse_gen`

## Requirements
- R1: While reset is asserted and right after it, `pulse_out` is 0, `fifo_level` is 0, `underflow` and `overflow` are 0, and `wr_ready` is 1.
- R2: With the gate active, `pulse_out` repeats without end: it is high for exactly H cycles and then low for exactly L cycles, where H and L are the active counts. After reset these counts are the parameters DEF_HIGH and DEF_LOW.
- R3: A count of 0 in either phase behaves as a count of 1.
- R4: The gate is active when `gate_in` equals `gate_pol` (1 means active high, 0 means active low). If the gate is sampled inactive at a clock edge, `pulse_out` is 0 after that edge and stays 0 while the gate remains inactive.
- R5: When the gate becomes active again, `pulse_out` goes to 1 at the first edge that samples the gate active, and the high phase lasts the full H cycles.
- R6: In static mode, `cfg_load` captures `cfg_high`/`cfg_low` as the pending setting. The period in progress finishes with its old counts, and the new counts take effect from the next period.
- R7: In queued mode, a rising edge on `smp_clk` moves the oldest FIFO entry into the pending setting SYNC_STAGES+1 cycles later. `fifo_level` drops by one, and the entry's counts govern the periods that start after that point.
- R8: In queued mode, a `smp_clk` rising edge that finds the FIFO empty leaves the counts unchanged and sets `underflow`. The flag stays set until reset.
- R9: The FIFO holds 16 entries. When it is full, `wr_ready` is 0, a `wr_valid` beat is dropped, `fifo_level` stays 16, and `overflow` becomes 1 and stays set until reset.
- R10: In static mode, `smp_clk` edges neither pop the FIFO nor set `underflow`. In queued mode, `cfg_load` has no effect on the output.
- R11: A write beat accepted while no pop happens in the same cycle raises `fifo_level` by one on the next cycle. Writes are accepted in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 1 | 0 static update, 1 queued update |
| cfg_high | input | W | High-phase count for static update |
| cfg_low | input | W | Low-phase count for static update |
| cfg_load | input | 1 | Static update strobe |
| gate_in | input | 1 | Gate signal |
| gate_pol | input | 1 | Gate active level |
| smp_clk | input | 1 | Sample clock for queued update |
| wr_valid | input | 1 | FIFO write beat valid |
| wr_ready | output | 1 | FIFO can accept a beat |
| wr_high | input | W | High-phase count of the beat |
| wr_low | input | W | Low-phase count of the beat |
| pulse_out | output | 1 | Pulse train |
| fifo_level | output | $clog2(DEPTH+1) | Entries in the FIFO |
| underflow | output | 1 | Sticky: sample edge found the FIFO empty |
| overflow | output | 1 | Sticky: beat dropped while full |

## Verification
The output register updates one cycle after the gate or the phase counter is sampled. A queued pop lands SYNC_STAGES+1 cycles after the `smp_clk` rise, and a write beat shows in `fifo_level` one cycle after it is accepted. The bench drives every input on the falling clock edge and samples on the falling edge. It measures phase lengths by counting consecutive falling-edge samples from an observed rise of `pulse_out`. Each sample-clock pulse is held for four cycles high and four cycles low before the level and flags are read, which is longer than the pop latency. Mid-period updates are issued in the first high cycle, so the old period can be measured before the new counts apply.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic { PH_HIGH = 1'b0, PH_LOW = 1'b1 } phase_e;
  typedef enum logic { MODE_STATIC = 1'b0, MODE_QUEUED = 1'b1 } mode_e;
endpackage

// File: rtl/pgen_edge_sync.sv
module pgen_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sr;
  logic              last_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[0] <= 1'b0;
          else        sr[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sr[gi] <= 1'b0;
          else        sr[gi] <= sr[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sr[STAGES-1];
  end

  assign rise = sr[STAGES-1] & ~last_q;

  // R7
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pgen_fifo.sv
module pgen_fifo #(
  parameter int DW    = 64,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  output logic          push_rdy,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic [LW-1:0] level,
  output logic          ovf
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, do_push, do_pop;

  assign full     = (level == LW'(DEPTH));
  assign empty    = (level == '0);
  assign push_rdy = ~full;
  assign do_push  = push_req & ~full;
  assign do_pop   = pop & ~empty;
  assign head     = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
      if (push_req && full) ovf <= 1'b1;
    end
  end

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop) |=> ($stable(level) && ovf));
  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !full && !pop) |=> (level == $past(level) + LW'(1)));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

// File: rtl/pgen_core.sv
module pgen_core
  import pgen_pkg::*;
#(
  parameter int W        = 32,
  parameter int DEF_HIGH = 4,
  parameter int DEF_LOW  = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate_ok,
  input  logic         nxt_vld,
  input  logic [W-1:0] nxt_high,
  input  logic [W-1:0] nxt_low,
  output logic         take,
  output logic         pulse_out
);
  phase_e       ph;
  logic         run;
  logic [W-1:0] cnt, act_high, act_low, hi_eff, lo_eff;
  logic         restart;

  assign hi_eff  = (act_high == '0) ? W'(1) : act_high;
  assign lo_eff  = (act_low  == '0) ? W'(1) : act_low;
  assign restart = gate_ok & (~run | (ph == PH_LOW && cnt >= lo_eff));
  assign take    = restart & nxt_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      ph        <= PH_HIGH;
      cnt       <= '0;
      pulse_out <= 1'b0;
      act_high  <= W'(DEF_HIGH);
      act_low   <= W'(DEF_LOW);
    end else if (!gate_ok) begin
      run       <= 1'b0;
      ph        <= PH_HIGH;
      cnt       <= '0;
      pulse_out <= 1'b0;
    end else if (restart) begin
      run       <= 1'b1;
      ph        <= PH_HIGH;
      cnt       <= W'(1);
      pulse_out <= 1'b1;
      if (nxt_vld) begin
        act_high <= nxt_high;
        act_low  <= nxt_low;
      end
    end else if (ph == PH_HIGH && cnt >= hi_eff) begin
      ph        <= PH_LOW;
      cnt       <= W'(1);
      pulse_out <= 1'b0;
    end else begin
      cnt <= cnt + W'(1);
    end
  end

  // R4
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_ok |=> !pulse_out);
  // R5
  gate_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_ok && !run) |=> pulse_out);
  // R6
  hold_setting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(act_high) && $stable(act_low)));
endmodule

// File: rtl/gated_pulse_gen.sv
module gated_pulse_gen
  import pgen_pkg::*;
#(
  parameter int W           = 32,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_HIGH    = 4,
  parameter int DEF_LOW     = 6,
  localparam int LW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic [W-1:0]  cfg_high,
  input  logic [W-1:0]  cfg_low,
  input  logic          cfg_load,
  input  logic          gate_in,
  input  logic          gate_pol,
  input  logic          smp_clk,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [W-1:0]  wr_high,
  input  logic [W-1:0]  wr_low,
  output logic          pulse_out,
  output logic [LW-1:0] fifo_level,
  output logic          underflow,
  output logic          overflow
);
  logic           smp_rise, fifo_empty, pop, load_static, load_any, take, gate_ok;
  logic [2*W-1:0] head;
  logic           pend_vld;
  logic [W-1:0]   pend_high, pend_low;
  mode_e          mode;

  assign mode        = mode_e'(mode_sel);
  assign gate_ok     = (gate_in == gate_pol);
  assign load_static = (mode == MODE_STATIC) & cfg_load;
  assign pop         = (mode == MODE_QUEUED) & smp_rise & ~fifo_empty;
  assign load_any    = load_static | pop;

  pgen_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (smp_clk),
    .rise     (smp_rise)
  );

  pgen_fifo #(.DW(2*W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (wr_valid),
    .push_data ({wr_high, wr_low}),
    .push_rdy  (wr_ready),
    .pop       (pop),
    .head      (head),
    .empty     (fifo_empty),
    .level     (fifo_level),
    .ovf       (overflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_high <= '0;
      pend_low  <= '0;
      underflow <= 1'b0;
    end else begin
      pend_vld <= (pend_vld & ~take) | load_any;
      if (load_static) begin
        pend_high <= cfg_high;
        pend_low  <= cfg_low;
      end else if (pop) begin
        pend_high <= head[2*W-1:W];
        pend_low  <= head[W-1:0];
      end
      if (mode == MODE_QUEUED && smp_rise && fifo_empty) underflow <= 1'b1;
    end
  end

  pgen_core #(.W(W), .DEF_HIGH(DEF_HIGH), .DEF_LOW(DEF_LOW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_ok   (gate_ok),
    .nxt_vld   (pend_vld),
    .nxt_high  (pend_high),
    .nxt_low   (pend_low),
    .take      (take),
    .pulse_out (pulse_out)
  );

  // R8
  underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && smp_rise && fifo_empty) |=> underflow);
  // R8
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  // R10
  static_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && !wr_valid) |=> $stable(fifo_level));
  // R7
  pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !wr_valid) |=> (fifo_level == $past(fifo_level) - LW'(1)));
endmodule

// File: tb/gated_pulse_gen_tb.sv
module gated_pulse_gen_tb;
  localparam int W = 32;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int DH = 4;
  localparam int DL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0, cfg_load = 1'b0, gate_in = 1'b1, gate_pol = 1'b1;
  logic smp_clk = 1'b0, wr_valid = 1'b0;
  logic [W-1:0] cfg_high = '0, cfg_low = '0, wr_high = '0, wr_low = '0;
  logic wr_ready, pulse_out, underflow, overflow;
  logic [LW-1:0] fifo_level;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  gated_pulse_gen #(.W(W), .DEPTH(DEPTH), .DEF_HIGH(DH), .DEF_LOW(DL)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cfg_high(cfg_high),
    .cfg_low(cfg_low), .cfg_load(cfg_load), .gate_in(gate_in),
    .gate_pol(gate_pol), .smp_clk(smp_clk), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_high(wr_high), .wr_low(wr_low),
    .pulse_out(pulse_out), .fifo_level(fifo_level),
    .underflow(underflow), .overflow(overflow)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wait_rise();
    logic prev = pulse_out;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (pulse_out && !prev) return;
      prev = pulse_out;
    end
    check("R2 no rise seen", 0, 1);
  endtask

  // Called at the first high sample; returns at the first high sample of the next period.
  task automatic count_pulse(output int h, output int l);
    h = 0; l = 0;
    while (pulse_out && h < 2000) begin h++; @(negedge clk); cfg_load = 1'b0; end
    while (!pulse_out && l < 2000) begin l++; @(negedge clk); cfg_load = 1'b0; end
  endtask

  task automatic push(input int hi, input int lo);
    wr_high = W'(hi); wr_low = W'(lo); wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic smp_pulse();
    smp_clk = 1'b1;
    repeat (4) @(negedge clk);
    smp_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 pulse_out in reset", pulse_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 fifo_level", fifo_level, 0);
    check("R1 underflow", underflow, 0);
    check("R1 overflow", overflow, 0);
    check("R1 wr_ready", wr_ready, 1);
  endtask

  task automatic t_default();
    int h, l;
    wait_rise();
    count_pulse(h, l);
    check("R2 default high", h, DH);
    check("R2 default low", l, DL);
    count_pulse(h, l);
    check("R2 repeat high", h, DH);
    check("R2 repeat low", l, DL);
  endtask

  task automatic t_gate();
    int h, l;
    gate_in = 1'b0;
    @(negedge clk);
    check("R4 gate off output", pulse_out, 0);
    repeat (12) @(negedge clk);
    check("R4 stays low", pulse_out, 0);
    gate_pol = 1'b0;
    @(negedge clk);
    check("R5 restart high", pulse_out, 1);
    count_pulse(h, l);
    check("R5 full high phase", h, DH);
    check("R4 active-low gate low", l, DL);
    gate_in = 1'b1;
    @(negedge clk);
    check("R4 active-low gate off", pulse_out, 0);
    gate_pol = 1'b1;
  endtask

  task automatic t_static();
    int h, l;
    wait_rise();
    cfg_high = 2; cfg_low = 3; cfg_load = 1'b1;
    count_pulse(h, l);
    check("R6 old high kept", h, DH);
    check("R6 old low kept", l, DL);
    count_pulse(h, l);
    check("R6 new high", h, 2);
    check("R6 new low", l, 3);
  endtask

  task automatic t_zero();
    int h, l;
    wait_rise();
    cfg_high = 0; cfg_low = 0; cfg_load = 1'b1;
    count_pulse(h, l);
    count_pulse(h, l);
    check("R3 zero high", h, 1);
    check("R3 zero low", l, 1);
  endtask

  task automatic t_fill_static();
    push(2, 2);
    check("R11 level after write", fifo_level, 1);
    push(3, 1);
    push(1, 3);
    check("R11 level three", fifo_level, 3);
    smp_pulse();
    check("R10 static no pop", fifo_level, 3);
    check("R10 static no underflow", underflow, 0);
  endtask

  task automatic t_queued();
    int h, l;
    mode_sel = 1'b1;
    smp_pulse();
    check("R7 pop level", fifo_level, 2);
    wait_rise();
    count_pulse(h, l);
    check("R7 queued high", h, 2);
    check("R7 queued low", l, 2);
    cfg_high = 6; cfg_low = 6; cfg_load = 1'b1;
    count_pulse(h, l);
    count_pulse(h, l);
    check("R10 queued ignores load high", h, 2);
    check("R10 queued ignores load low", l, 2);
    smp_pulse();
    smp_pulse();
    check("R7 drained", fifo_level, 0);
    check("R8 no underflow yet", underflow, 0);
    wait_rise();
    count_pulse(h, l);
    check("R7 last high", h, 1);
    check("R7 last low", l, 3);
    smp_pulse();
    check("R8 underflow set", underflow, 1);
    wait_rise();
    count_pulse(h, l);
    check("R8 kept high", h, 1);
    check("R8 kept low", l, 3);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) push(5, 5);
    check("R9 full level", fifo_level, DEPTH);
    check("R9 ready low", wr_ready, 0);
    push(7, 7);
    check("R9 level held", fifo_level, DEPTH);
    check("R9 overflow set", overflow, 1);
    repeat (3) @(negedge clk);
    check("R9 overflow sticky", overflow, 1);
    check("R8 underflow sticky", underflow, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_default();
    t_gate();
    t_static();
    t_zero();
    t_fill_static();
    t_queued();
    t_overflow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule